// File: doc/BRIEF.md
# Mesh Router VC and Switch Allocator

This block is the allocation stage of a five-port mesh router that carries four virtual channels on every port. Each input virtual channel that has a flit at the head of its queue presents one output port, already chosen by look-ahead routing upstream, together with a flag saying whether that flit closes its packet. In one combinational pass the block decides which input virtual channels may move a flit this cycle. The decision is returned to the input buffers as a one-hot virtual-channel grant per input port. One cycle later the block presents a one-hot input-port select for each output port, aligned with the flit that leaves the buffer register, to steer the crossbar.

Allocation runs in two parts. Output virtual channels are claimed by packets through per-output-VC round-robin arbiters that hold ownership from the first flit of a multi-flit packet until its closing flit. Only the output side of this stage exists, because each input VC aims at a single port at a time. Downstream on/off back-pressure masks each output VC. The survivors then go through separable input-first switch allocation: one round-robin arbiter per input picks a virtual channel, and one round-robin arbiter per output picks an input. Every arbiter moves its priority only when a flit actually transfers.

Top module: `lsa_switch_alloc`

## Requirements
- R1: After reset no output VC is owned, all priority pointers favour index 0 first, and `xbar_sel` is all zero. With no requests, `vc_grant` is all zero.
- R2: `vc_grant` bit (i*NVC+v) is set only when input i, VC v requests some port in `req_oh`. A flit is always granted on the same VC index it arrived on.
- R3: An input VC requesting output o on VC v is not granted while `ds_off` bit (o*NVC+v) is high. It becomes eligible again once that bit drops.
- R4: When input i moves a flit with `req_last` low on VC v toward output o, that output VC is owned by input i. No other input is granted VC v toward o until input i moves a flit there with `req_last` high, even in cycles when input i does not request.
- R5: A granted flit with `req_last` high releases the output VC in the same transfer. A single-flit packet (head and tail at once) therefore takes and frees the VC in one cycle.
- R6: Each input port receives at most one VC grant per cycle.
- R7: Each output port accepts at most one input per cycle. Inputs on different VCs of the same output still compete for that output.
- R8: Among the VCs of one input that won their output VC, the per-input arbiter picks round-robin, starting from the VC after the one last granted on that input.
- R9: Among the inputs whose chosen flit targets output o, the per-output arbiter picks round-robin, starting from the input after the one last granted on o.
- R10: A free output VC is given round-robin among the inputs requesting it, starting from the input after the last one that moved a flit through it.
- R11: `xbar_sel` bit (o*NPORT+i) is high in the cycle after input i was granted a flit toward output o, and low otherwise.
- R12: A priority pointer moves only when its arbiter's winner actually transfers a flit. A VC that wins at its input but loses at the output keeps its input priority for the next cycle.

Port indices follow the encoding LOCAL=0, EAST=1, NORTH=2, WEST=3, SOUTH=4. `req_oh` bit ((i*NVC+v)*NPORT+o) means that input i, VC v wants output o, with at most one bit set per input VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_oh | input | NPORT*NVC*NPORT | One-hot output-port request per input VC |
| req_last | input | NPORT*NVC | Head-of-queue flit of that input VC closes its packet |
| ds_off | input | NPORT*NVC | Downstream off signal per output VC, index o*NVC+v |
| vc_grant | output | NPORT*NVC | One-hot granted VC per input port, index i*NVC+v |
| xbar_sel | output | NPORT*NPORT | Registered one-hot input select per output port, index o*NPORT+i |

## Verification
The bench builds the block with its default five ports and four virtual channels, which matches the real router. At that size every output VC can see up to five competing inputs, every input has four VCs to choose among, and any of the four possible turns or straight paths can collide at an output. Directed sequences drive an ownership handoff across an idle owner cycle, a back-pressured VC, and a stage-two loss that must leave the input pointer untouched. Random multi-flit traffic with random on/off then runs against a cycle-accurate model of the arbitration order.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int PORTS = 5;
    localparam int VCS   = 4;

    // Port numbering used by look-ahead routing and the crossbar select.
    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_NORTH = 3'd2,
        DIR_WEST  = 3'd3,
        DIR_SOUTH = 3'd4
    } dir_e;

    // Flat bit position of "input i, VC v wants output o".
    function automatic int req_pos(input int i, input int v, input int o,
                                   input int nvc, input int np);
        return (i * nvc + v) * np + o;
    endfunction

endpackage

// File: rtl/lsa_rr_arb.sv
module lsa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] win_idx;

    // Search starts one past the most recent winner.
    always_comb begin
        gnt     = '0;
        win_idx = last_q;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win_idx  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IW'(N - 1);
        else if (adv && (|gnt))
            last_q <= win_idx;
    end

endmodule

// File: rtl/lsa_vc_stage.sv
module lsa_vc_stage #(
    parameter int NP = 5,
    parameter int NV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NP*NV*NP-1:0] req_oh,
    input  logic [NP*NV-1:0]  req_last,
    input  logic [NP*NV-1:0]  ds_off,
    input  logic [NP*NV-1:0]  xfer_gnt,
    output logic [NP*NV-1:0]  va_win
);
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic [NP-1:0] ov_gnt [NP][NV];

    for (genvar o = 0; o < NP; o++) begin : g_out
        for (genvar v = 0; v < NV; v++) begin : g_vc
            logic          own_q;
            logic [IW-1:0] who_q;
            logic [NP-1:0] cand;
            logic [NP-1:0] eff;
            logic [NP-1:0] moved;

            // Eligible requesters, narrowed to the owner while the VC is held.
            always_comb begin
                for (int i = 0; i < NP; i++)
                    cand[i] = req_oh[(i*NV+v)*NP+o] & ~ds_off[o*NV+v];
                eff = cand;
                if (own_q) begin
                    eff        = '0;
                    eff[who_q] = cand[who_q];
                end
            end

            always_comb begin
                for (int i = 0; i < NP; i++)
                    moved[i] = xfer_gnt[i*NV+v] & req_oh[(i*NV+v)*NP+o];
            end

            lsa_rr_arb #(.N(NP)) u_arb (
                .clk (clk),
                .rst (rst),
                .req (eff),
                .adv (|moved),
                .gnt (ov_gnt[o][v])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    own_q <= 1'b0;
                    who_q <= '0;
                end else begin
                    for (int i = 0; i < NP; i++) begin
                        if (moved[i]) begin
                            own_q <= ~req_last[i*NV+v];
                            who_q <= IW'(i);
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int v = 0; v < NV; v++) begin
                va_win[i*NV+v] = 1'b0;
                for (int o = 0; o < NP; o++)
                    va_win[i*NV+v] = va_win[i*NV+v] | ov_gnt[o][v][i];
            end
        end
    end

endmodule

// File: rtl/lsa_sw_stage.sv
module lsa_sw_stage #(
    parameter int NP = 5,
    parameter int NV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NP*NV-1:0]    va_win,
    input  logic [NP*NV*NP-1:0] req_oh,
    output logic [NP*NV-1:0]    in_gnt,
    output logic [NP*NP-1:0]    sa_sel
);
    logic [NV-1:0] s1_vc  [NP];
    logic [NP-1:0] s1_dst [NP];
    logic [NP-1:0] s2_req [NP];
    logic [NP-1:0] s2_gnt [NP];
    logic [NP-1:0] in_won;

    // Stage one: one VC per input.
    for (genvar i = 0; i < NP; i++) begin : g_in
        lsa_rr_arb #(.N(NV)) u_s1 (
            .clk (clk),
            .rst (rst),
            .req (va_win[i*NV +: NV]),
            .adv (in_won[i]),
            .gnt (s1_vc[i])
        );
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            s1_dst[i] = '0;
            for (int v = 0; v < NV; v++)
                s1_dst[i] = s1_dst[i] | (req_oh[(i*NV+v)*NP +: NP] & {NP{s1_vc[i][v]}});
        end
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                s2_req[o][i] = s1_dst[i][o];
    end

    // Stage two: one input per output.
    for (genvar o = 0; o < NP; o++) begin : g_op
        lsa_rr_arb #(.N(NP)) u_s2 (
            .clk (clk),
            .rst (rst),
            .req (s2_req[o]),
            .adv (1'b1),
            .gnt (s2_gnt[o])
        );
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_won[i] = 1'b0;
            for (int o = 0; o < NP; o++)
                in_won[i] = in_won[i] | s2_gnt[o][i];
            for (int v = 0; v < NV; v++)
                in_gnt[i*NV+v] = s1_vc[i][v] & in_won[i];
        end
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                sa_sel[o*NP+i] = s2_gnt[o][i];
    end

endmodule

// File: rtl/lsa_switch_alloc.sv
module lsa_switch_alloc #(
    parameter int NPORT = lsa_pkg::PORTS,
    parameter int NVC   = lsa_pkg::VCS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT*NVC*NPORT-1:0] req_oh,
    input  logic [NPORT*NVC-1:0]      req_last,
    input  logic [NPORT*NVC-1:0]      ds_off,
    output logic [NPORT*NVC-1:0]      vc_grant,
    output logic [NPORT*NPORT-1:0]    xbar_sel
);
    logic [NPORT*NVC-1:0]   va_win;
    logic [NPORT*NVC-1:0]   in_gnt;
    logic [NPORT*NPORT-1:0] sa_sel;

    lsa_vc_stage #(.NP(NPORT), .NV(NVC)) u_vc (
        .clk      (clk),
        .rst      (rst),
        .req_oh   (req_oh),
        .req_last (req_last),
        .ds_off   (ds_off),
        .xfer_gnt (in_gnt),
        .va_win   (va_win)
    );

    lsa_sw_stage #(.NP(NPORT), .NV(NVC)) u_sw (
        .clk    (clk),
        .rst    (rst),
        .va_win (va_win),
        .req_oh (req_oh),
        .in_gnt (in_gnt),
        .sa_sel (sa_sel)
    );

    assign vc_grant = in_gnt;

    // Select lines meet the flit one stage after the grant.
    always_ff @(posedge clk) begin
        if (rst)
            xbar_sel <= '0;
        else
            xbar_sel <= sa_sel;
    end

endmodule

// File: rtl/lsa_switch_alloc_chk.sv
module lsa_switch_alloc_chk #(
    parameter int NPORT = 5,
    parameter int NVC   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NPORT*NVC*NPORT-1:0] req_oh,
    input logic [NPORT*NVC-1:0]       req_last,
    input logic [NPORT*NVC-1:0]       ds_off,
    input logic [NPORT*NVC-1:0]       vc_grant,
    input logic [NPORT*NPORT-1:0]     xbar_sel
);
    logic [NPORT-1:0] to_o [NPORT];

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                to_o[o][i] = 1'b0;
                for (int v = 0; v < NVC; v++)
                    to_o[o][i] = to_o[o][i] |
                        (vc_grant[i*NVC+v] & req_oh[(i*NVC+v)*NPORT+o]);
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        // R6
        one_vc_per_input_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(vc_grant[i*NVC +: NVC]));

        for (genvar v = 0; v < NVC; v++) begin : g_v
            // R2
            grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
                vc_grant[i*NVC+v] |-> (|req_oh[(i*NVC+v)*NPORT +: NPORT]));

            for (genvar o = 0; o < NPORT; o++) begin : g_o
                // R3
                off_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst)
                    (vc_grant[i*NVC+v] && req_oh[(i*NVC+v)*NPORT+o]) |-> !ds_off[o*NVC+v]);
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // R7
        one_input_per_output_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(xbar_sel[o*NPORT +: NPORT]));

        for (genvar i = 0; i < NPORT; i++) begin : g_sel
            // R11
            sel_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
                xbar_sel[o*NPORT+i] |-> $past(to_o[o][i]));
        end
    end

endmodule

bind lsa_switch_alloc lsa_switch_alloc_chk #(.NPORT(NPORT), .NVC(NVC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_oh   (req_oh),
    .req_last (req_last),
    .ds_off   (ds_off),
    .vc_grant (vc_grant),
    .xbar_sel (xbar_sel)
);

// File: tb/lsa_switch_alloc_tb.sv
module lsa_switch_alloc_tb;
    import lsa_pkg::*;

    localparam int P = PORTS;
    localparam int V = VCS;

    logic               clk = 1'b0;
    logic               rst;
    logic [P*V*P-1:0]   req_oh;
    logic [P*V-1:0]     req_last;
    logic [P*V-1:0]     ds_off;
    logic [P*V-1:0]     vc_grant;
    logic [P*P-1:0]     xbar_sel;

    lsa_switch_alloc #(.NPORT(P), .NVC(V)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .req_oh   (req_oh),
        .req_last (req_last),
        .ds_off   (ds_off),
        .vc_grant (vc_grant),
        .xbar_sel (xbar_sel)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Stimulus
    bit rq    [P][V];
    int rdst  [P][V];
    bit rlast [P][V];
    bit off   [P][V];   // indexed [output][vc]

    // Reference state
    bit own_v [P][V];
    int own_i [P][V];
    int pva   [P][V];
    int ps1   [P];
    int ps2   [P];
    int eg    [P];
    bit esel  [P][P];
    bit psel  [P][P];

    // Random packet state
    int rem  [P][V];
    int pdst [P][V];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int rr_pick(input bit [7:0] r, input int n, input int last);
        for (int k = 1; k <= n; k++) begin
            int idx;
            idx = (last + k) % n;
            if (r[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic clear_stim();
        for (int i = 0; i < P; i++)
            for (int v = 0; v < V; v++) begin
                rq[i][v] = 0; rdst[i][v] = 0; rlast[i][v] = 0; off[i][v] = 0;
            end
    endtask

    task automatic model_reset();
        for (int a = 0; a < P; a++) begin
            for (int v = 0; v < V; v++) begin
                own_v[a][v] = 0; own_i[a][v] = 0; pva[a][v] = P - 1;
                rem[a][v] = 0; pdst[a][v] = 0;
            end
            ps1[a] = V - 1; ps2[a] = P - 1;
            for (int b = 0; b < P; b++) psel[a][b] = 0;
        end
    endtask

    task automatic drive();
        for (int i = 0; i < P; i++)
            for (int v = 0; v < V; v++) begin
                for (int o = 0; o < P; o++)
                    req_oh[req_pos(i, v, o, V, P)] = rq[i][v] && (rdst[i][v] == o);
                req_last[i*V+v] = rlast[i][v];
                ds_off[i*V+v]   = off[i][v];
            end
    endtask

    task automatic model_eval();
        bit va [P][V];
        int c1 [P];
        for (int i = 0; i < P; i++) begin
            eg[i] = -1;
            for (int v = 0; v < V; v++) va[i][v] = 0;
            for (int o = 0; o < P; o++) esel[i][o] = 0;
        end
        for (int o = 0; o < P; o++)
            for (int v = 0; v < V; v++) begin
                bit [7:0] r;
                int w;
                r = '0;
                for (int i = 0; i < P; i++)
                    if (rq[i][v] && rdst[i][v] == o && !off[o][v] &&
                        (!own_v[o][v] || own_i[o][v] == i))
                        r[i] = 1'b1;
                w = rr_pick(r, P, pva[o][v]);
                if (w >= 0) va[w][v] = 1;
            end
        for (int i = 0; i < P; i++) begin
            bit [7:0] r;
            r = '0;
            for (int v = 0; v < V; v++) r[v] = va[i][v];
            c1[i] = rr_pick(r, V, ps1[i]);
        end
        for (int o = 0; o < P; o++) begin
            bit [7:0] r;
            int w;
            r = '0;
            for (int i = 0; i < P; i++)
                if (c1[i] >= 0 && rdst[i][c1[i]] == o) r[i] = 1'b1;
            w = rr_pick(r, P, ps2[o]);
            if (w >= 0) begin
                esel[o][w] = 1;
                eg[w]      = c1[w];
            end
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < P; i++)
            if (eg[i] >= 0) begin
                int v;
                int o;
                v = eg[i];
                o = rdst[i][v];
                pva[o][v] = i;
                ps1[i]    = v;
                ps2[o]    = i;
                own_v[o][v] = !rlast[i][v];
                own_i[o][v] = i;
            end
        for (int a = 0; a < P; a++)
            for (int b = 0; b < P; b++) psel[a][b] = esel[a][b];
    endtask

    task automatic eval_cyc(input string tag);
        logic [P*P-1:0] ps;
        drive();
        #1;
        model_eval();
        for (int i = 0; i < P; i++) begin
            logic [V-1:0] e;
            e = (eg[i] >= 0) ? V'(1 << eg[i]) : '0;
            chk(vc_grant[i*V +: V] == e, tag, $sformatf("vc_grant input %0d", i),
                int'(vc_grant[i*V +: V]), int'(e));
        end
        for (int o = 0; o < P; o++)
            for (int i = 0; i < P; i++) ps[o*P+i] = psel[o][i];
        chk(xbar_sel == ps, "R11", "xbar_sel", int'(xbar_sel), int'(ps));
    endtask

    task automatic adv_cyc();
        model_update();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_g(input int i, input logic [V-1:0] e, input string tag);
        chk(vc_grant[i*V +: V] == e, tag, $sformatf("directed grant input %0d", i),
            int'(vc_grant[i*V +: V]), int'(e));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        clear_stim();
        model_reset();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        eval_cyc("R1");
        chk(xbar_sel == '0, "R1", "xbar_sel after reset", int'(xbar_sel), 0);
        chk(vc_grant == '0, "R1", "vc_grant idle", int'(vc_grant), 0);
        adv_cyc();

        // R10 / R4 / R5: ownership of NORTH VC2
        rq[3][2] = 1; rdst[3][2] = DIR_NORTH; rlast[3][2] = 0;
        eval_cyc("R10"); expect_g(3, 4'b0100, "R10"); adv_cyc();
        rq[3][2] = 0;
        rq[1][2] = 1; rdst[1][2] = DIR_NORTH; rlast[1][2] = 0;
        eval_cyc("R4"); expect_g(1, 4'b0000, "R4"); adv_cyc();
        rq[3][2] = 1; rlast[3][2] = 1;
        eval_cyc("R4"); expect_g(3, 4'b0100, "R5"); expect_g(1, 4'b0000, "R4"); adv_cyc();
        rq[3][2] = 0;
        eval_cyc("R5"); expect_g(1, 4'b0100, "R5"); adv_cyc();
        rlast[1][2] = 1;
        eval_cyc("R5"); expect_g(1, 4'b0100, "R5"); adv_cyc();
        clear_stim();

        // R3: back-pressure on EAST VC1
        rq[0][1] = 1; rdst[0][1] = DIR_EAST; rlast[0][1] = 1; off[DIR_EAST][1] = 1;
        eval_cyc("R3"); expect_g(0, 4'b0000, "R3"); adv_cyc();
        off[DIR_EAST][1] = 0;
        eval_cyc("R3"); expect_g(0, 4'b0010, "R3"); adv_cyc();
        clear_stim();

        // R7 / R9: two inputs on different VCs toward SOUTH
        rq[0][0] = 1; rdst[0][0] = DIR_SOUTH; rlast[0][0] = 1;
        rq[2][3] = 1; rdst[2][3] = DIR_SOUTH; rlast[2][3] = 1;
        eval_cyc("R9"); expect_g(0, 4'b0001, "R7"); expect_g(2, 4'b0000, "R7"); adv_cyc();
        eval_cyc("R9"); expect_g(0, 4'b0000, "R9"); expect_g(2, 4'b1000, "R9"); adv_cyc();
        clear_stim();

        // R8: one input, two VCs to different outputs
        rq[4][0] = 1; rdst[4][0] = DIR_EAST; rlast[4][0] = 1;
        rq[4][1] = 1; rdst[4][1] = DIR_WEST; rlast[4][1] = 1;
        eval_cyc("R8"); expect_g(4, 4'b0001, "R8"); adv_cyc();
        eval_cyc("R8"); expect_g(4, 4'b0010, "R8"); adv_cyc();
        clear_stim();

        // R12: stage-two loser keeps its input priority
        rq[0][0] = 1; rdst[0][0] = DIR_EAST;  rlast[0][0] = 1;
        rq[2][1] = 1; rdst[2][1] = DIR_EAST;  rlast[2][1] = 1;
        rq[2][2] = 1; rdst[2][2] = DIR_NORTH; rlast[2][2] = 1;
        eval_cyc("R12"); expect_g(0, 4'b0001, "R12"); expect_g(2, 4'b0000, "R12"); adv_cyc();
        eval_cyc("R12"); expect_g(2, 4'b0010, "R12"); expect_g(0, 4'b0000, "R12"); adv_cyc();
        clear_stim();

        // Random multi-flit traffic with random back-pressure
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < P; i++)
                for (int v = 0; v < V; v++) begin
                    if (rem[i][v] == 0 && ($urandom % 3) == 0) begin
                        rem[i][v]  = 1 + int'($urandom % 3);
                        pdst[i][v] = int'($urandom % P);
                    end
                    rq[i][v]    = (rem[i][v] > 0) && (($urandom % 4) != 0);
                    rdst[i][v]  = pdst[i][v];
                    rlast[i][v] = (rem[i][v] == 1);
                    off[i][v]   = (($urandom % 6) == 0);
                end
            eval_cyc("R10");
            for (int i = 0; i < P; i++)
                if (eg[i] >= 0) rem[i][eg[i]]--;
            adv_cyc();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule